// File: doc/BRIEF.md
# Indirect Host Register Slave

This block sits on the peripheral side of a 16-bit parallel host bus. The data and address lines are separate. Chip select, read strobe and write strobe are active low. A separate select pin, `reg_sel`, chooses which of two access registers a strobe touches. With `reg_sel` low the host reaches the index register. With `reg_sel` high it reaches the data window, which maps onto whichever of the 128 internal registers the index currently names. The index stays the same after each access, so repeated data accesses all hit the same register.

Three internal registers have fixed roles:

- Index 0x0C holds the interrupt enables.
- Index 0x0E is the interrupt source register. The host cannot write it, and a host read of it returns the pending sources and clears them.
- Index 0x05 is the video-control register. Its bits 2:1 select the rate-control mode.

The encoder side raises interrupt sources through the `ev_set` pulse inputs. The block drives an active-high interrupt request whenever an enabled source is pending.

Top module: `hreg_indirect_slave`

## Requirements
- R1: After reset, the index, all internal registers, the interrupt sources, `dout`, `irq` and `rate_mode` are all zero.
- R2: A write with `reg_sel` low stores `din[6:0]` as the index; `din[15:7]` are ignored.
- R3: A write with `reg_sel` high stores `din` in the register named by the index. The index does not change after a data access.
- R4: A read with `reg_sel` low returns the index zero-extended to 16 bits on `dout`. A read with `reg_sel` high returns the indexed register. `dout` holds that value until the next read.
- R5: The interrupt-enable register is at index 0x0C. `irq` is high exactly when some source bit is pending and its enable bit (same position) is set.
- R6: A high bit on `ev_set` sets the matching source bit on the next clock edge. The bit positions are:
  - bit 0: FIFO ready
  - bit 1: end of data
  - bit 6: ready
- R7: A read of index 0x0E returns the pending sources and clears them. A source raised on `ev_set` in the same cycle as the clearing read remains pending.
- R8: Host writes to index 0x0E have no effect on the sources.
- R9: Bits 2:1 of the video-control register at index 0x05 drive `rate_mode`: 0 is constant, 1 is capped maximum, 3 is variable.
- R10: A write to index 0x05 whose bits 2:1 equal the reserved value 2 leaves that field and `rate_mode` unchanged, but stores the other bits.
- R11: An access happens only on the first clock cycle in which the strobe is low while `cs_n` is low. A strobe held low for several cycles is one access, and strobes with `cs_n` high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| reg_sel | input | 1 | Access register select: 0 index, 1 data window |
| din | input | 16 | Host write data |
| ev_set | input | 8 | Interrupt source set pulses from the encoder side |
| dout | output | 16 | Host read data, registered |
| irq | output | 1 | Interrupt request, active high |
| rate_mode | output | 2 | Rate-control mode from video-control bits 2:1 |

## Verification
The assertions assume that the strobes and select lines are synchronous to `clk`, that `din` and `reg_sel` are stable in the cycle a strobe first goes low, and that read and write strobes are never low together. The bench drives every bus signal on the falling edge and holds it through at least one rising edge. It releases a strobe before starting the next access and never overlaps reads with writes. The `ev_set` pulses last exactly one cycle, except in the one case that deliberately lines a pulse up with a clearing read.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

    localparam int DATA_W   = 16;
    localparam int IDX_W    = 7;
    localparam int NUM_REGS = 1 << IDX_W;
    localparam int SRC_W    = 8;
    localparam int MODE_LSB = 1;
    localparam int MODE_W   = 2;

    localparam logic [IDX_W-1:0] IDX_VCTL    = 7'h05;
    localparam logic [IDX_W-1:0] IDX_IRQ_EN  = 7'h0C;
    localparam logic [IDX_W-1:0] IDX_IRQ_SRC = 7'h0E;

    typedef enum logic [MODE_W-1:0] {
        RATE_CONST = 2'd0,
        RATE_CAP   = 2'd1,
        RATE_RSVD  = 2'd2,
        RATE_VAR   = 2'd3
    } rate_mode_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic              sel;
        logic [DATA_W-1:0] wdata;
    } bus_op_t;

    function automatic logic mode_legal(input logic [MODE_W-1:0] f);
        return rate_mode_e'(f) != RATE_RSVD;
    endfunction

    // Keep the old mode field when the new one is the reserved code.
    function automatic logic [DATA_W-1:0] merge_vctl(input logic [DATA_W-1:0] old_v,
                                                     input logic [DATA_W-1:0] new_v);
        logic [DATA_W-1:0] r;
        r = new_v;
        if (!mode_legal(new_v[MODE_LSB +: MODE_W]))
            r[MODE_LSB +: MODE_W] = old_v[MODE_LSB +: MODE_W];
        return r;
    endfunction

endpackage

// File: rtl/hreg_host_if.sv
module hreg_host_if
    import hreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              sel,
    input  logic [DATA_W-1:0] din,
    output bus_op_t           op
);

    logic wr_n_q;
    logic rd_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_n_q <= 1'b1;
            rd_n_q <= 1'b1;
        end else begin
            wr_n_q <= wr_n;
            rd_n_q <= rd_n;
        end
    end

    always_comb begin
        op.wr    = !cs_n && !wr_n && wr_n_q;
        op.rd    = !cs_n && !rd_n && rd_n_q && wr_n;
        op.sel   = sel;
        op.wdata = din;
    end

    // R11: a held strobe never produces a second access
    assert_single_write_R11: assert property (@(posedge clk) disable iff (rst)
        op.wr |=> !op.wr);
    assert_single_read_R11: assert property (@(posedge clk) disable iff (rst)
        op.rd |=> !op.rd);

endmodule

// File: rtl/hreg_bank.sv
module hreg_bank
    import hreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    input  logic [SRC_W-1:0]  src,
    output logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] rdata,
    output logic [SRC_W-1:0]  ien,
    output rate_mode_e        rate
);

    logic [DATA_W-1:0] regs [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else if (op.wr) begin
            if (!op.sel) begin
                idx <= op.wdata[IDX_W-1:0];
            end else if (idx == IDX_VCTL) begin
                regs[idx] <= merge_vctl(regs[idx], op.wdata);
            end else if (idx != IDX_IRQ_SRC) begin
                regs[idx] <= op.wdata;
            end
        end
    end

    always_comb begin
        if (idx == IDX_IRQ_SRC) rdata = DATA_W'(src);
        else                    rdata = regs[idx];
    end

    assign ien  = regs[IDX_IRQ_EN][SRC_W-1:0];
    assign rate = rate_mode_e'(regs[IDX_VCTL][MODE_LSB +: MODE_W]);

    assert_index_load_R2: assert property (@(posedge clk) disable iff (rst)
        (op.wr && !op.sel) |=> idx == $past(op.wdata[IDX_W-1:0]));
    assert_index_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(op.wr && !op.sel) |=> $stable(idx));
    assert_mode_legal_R9: assert property (@(posedge clk) disable iff (rst)
        rate != RATE_RSVD);
    assert_reserved_keep_R10: assert property (@(posedge clk) disable iff (rst)
        (op.wr && op.sel && idx == IDX_VCTL && rate_mode_e'(op.wdata[MODE_LSB +: MODE_W]) == RATE_RSVD)
        |=> $stable(rate));

endmodule

// File: rtl/hreg_irq.sv
module hreg_irq
    import hreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] ev_set,
    input  logic             clr,
    input  logic [SRC_W-1:0] ien,
    output logic [SRC_W-1:0] src,
    output logic             irq
);

    for (genvar g = 0; g < SRC_W; g++) begin : g_src
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)            bit_q <= 1'b0;
            else if (clr)       bit_q <= ev_set[g];
            else if (ev_set[g]) bit_q <= 1'b1;
        end
        assign src[g] = bit_q;
    end

    assign irq = |(src & ien);

    assert_event_sets_R6: assert property (@(posedge clk) disable iff (rst)
        (|ev_set) |=> (src & $past(ev_set)) == $past(ev_set));
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (clr && ev_set == '0) |=> src == '0);
    assert_irq_masked_R5: assert property (@(posedge clk) disable iff (rst)
        (ien == '0) |-> !irq);

endmodule

// File: rtl/hreg_indirect_slave.sv
module hreg_indirect_slave
    import hreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] din,
    input  logic [SRC_W-1:0]  ev_set,
    output logic [DATA_W-1:0] dout,
    output logic              irq,
    output logic [MODE_W-1:0] rate_mode
);

    bus_op_t           op;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rdata;
    logic [SRC_W-1:0]  src;
    logic [SRC_W-1:0]  ien;
    rate_mode_e        rate;
    logic              clr;

    hreg_host_if u_host (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .rd_n (rd_n),
        .wr_n (wr_n),
        .sel  (reg_sel),
        .din  (din),
        .op   (op)
    );

    hreg_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .src   (src),
        .idx   (idx),
        .rdata (rdata),
        .ien   (ien),
        .rate  (rate)
    );

    assign clr = op.rd && op.sel && (idx == IDX_IRQ_SRC);

    hreg_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .ev_set (ev_set),
        .clr    (clr),
        .ien    (ien),
        .src    (src),
        .irq    (irq)
    );

    always_ff @(posedge clk) begin
        if (rst)        dout <= '0;
        else if (op.rd) dout <= op.sel ? rdata : DATA_W'(idx);
    end

    assign rate_mode = rate;

    assert_dout_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !op.rd |=> $stable(dout));

endmodule

// File: tb/test_hreg_indirect_slave.sv
module test_hreg_indirect_slave;
    import hreg_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, reg_sel = 1'b0;
    logic [15:0] din = '0;
    logic [7:0]  ev_set = '0;
    logic [15:0] dout;
    logic        irq;
    logic [1:0]  rate_mode;

    int vectors = 0;
    int fails = 0;

    always #5 clk = ~clk;

    hreg_indirect_slave i_hreg_indirect_slave (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .reg_sel(reg_sel), .din(din), .ev_set(ev_set),
        .dout(dout), .irq(irq), .rate_mode(rate_mode)
    );

    // {op, sel, data, expected}; op 0 write, 1 read, 2 event pulse, 3 status {irq, rate_mode}
    localparam int NV = 33;
    localparam logic [34:0] VEC [NV] = '{
        {2'd0, 1'b0, 16'h0005, 16'h0000},
        {2'd0, 1'b1, 16'h0002, 16'h0000},
        {2'd3, 1'b0, 16'h0000, 16'h0001}, // R9 capped mode
        {2'd1, 1'b1, 16'h0000, 16'h0002}, // R4 data read
        {2'd1, 1'b0, 16'h0000, 16'h0005}, // R4 index read
        {2'd0, 1'b0, 16'h0085, 16'h0000},
        {2'd1, 1'b0, 16'h0000, 16'h0005}, // R2 upper bits dropped
        {2'd0, 1'b1, 16'h0006, 16'h0000},
        {2'd3, 1'b0, 16'h0000, 16'h0003}, // R9 variable mode
        {2'd0, 1'b0, 16'h0030, 16'h0000},
        {2'd0, 1'b1, 16'hBEEF, 16'h0000},
        {2'd0, 1'b1, 16'h1234, 16'h0000},
        {2'd1, 1'b1, 16'h0000, 16'h1234}, // R3 same register overwritten
        {2'd1, 1'b0, 16'h0000, 16'h0030}, // R3 no increment
        {2'd0, 1'b0, 16'h000C, 16'h0000},
        {2'd0, 1'b1, 16'h0043, 16'h0000},
        {2'd1, 1'b1, 16'h0000, 16'h0043}, // R5 enable stored
        {2'd3, 1'b0, 16'h0000, 16'h0003}, // R5 nothing pending
        {2'd2, 1'b0, 16'h0041, 16'h0000},
        {2'd3, 1'b0, 16'h0000, 16'h0007}, // R5 R6 irq raised
        {2'd0, 1'b0, 16'h000E, 16'h0000},
        {2'd0, 1'b1, 16'hFFFF, 16'h0000}, // R8 write ignored
        {2'd1, 1'b1, 16'h0000, 16'h0041}, // R7 R8 pending returned
        {2'd1, 1'b1, 16'h0000, 16'h0000}, // R7 cleared
        {2'd3, 1'b0, 16'h0000, 16'h0003}, // R7 irq dropped
        {2'd2, 1'b0, 16'h0080, 16'h0000},
        {2'd3, 1'b0, 16'h0000, 16'h0003}, // R5 unenabled source
        {2'd1, 1'b1, 16'h0000, 16'h0080}, // R6 bit 7 pending
        {2'd1, 1'b1, 16'h0000, 16'h0000},
        {2'd2, 1'b0, 16'h0002, 16'h0000},
        {2'd3, 1'b0, 16'h0000, 16'h0007}, // R6 end of data raises irq
        {2'd1, 1'b1, 16'h0000, 16'h0002}, // R6 bit 1
        {2'd3, 1'b0, 16'h0000, 16'h0003}
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic s, input logic [15:0] d);
        @(negedge clk);
        cs_n = 1'b0; reg_sel = s; din = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic bus_read(input logic s, input logic [7:0] ev, output logic [15:0] q);
        @(negedge clk);
        cs_n = 1'b0; reg_sel = s; rd_n = 1'b0; ev_set = ev;
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1; ev_set = '0;
        q = dout;
    endtask

    task automatic pulse_ev(input logic [7:0] ev);
        @(negedge clk);
        ev_set = ev;
        @(negedge clk);
        ev_set = '0;
    endtask

    task automatic status_check(input string req, input logic [2:0] exp);
        @(negedge clk);
        check(req, {13'd0, irq, rate_mode}, {13'd0, exp});
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin : main
        logic [15:0] q;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 dout", dout, 16'h0000);
        check("R1 irq/rate", {13'd0, irq, rate_mode}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][34:33])
                2'd0: bus_write(VEC[i][32], VEC[i][31:16]);
                2'd1: begin
                    bus_read(VEC[i][32], 8'h00, q);
                    check($sformatf("vector %0d read", i), q, VEC[i][15:0]);
                end
                2'd2: pulse_ev(VEC[i][23:16]);
                default: status_check($sformatf("vector %0d status", i), VEC[i][2:0]);
            endcase
        end

        // R10: reserved mode code keeps the field, other bits stored
        bus_write(1'b0, 16'h0005);
        bus_write(1'b1, 16'h0104);
        bus_read(1'b1, 8'h00, q);
        check("R10 stored value", q, 16'h0106);
        status_check("R10 mode kept", 3'b011);

        // R11: deselected write ignored
        bus_write(1'b0, 16'h0030);
        @(negedge clk);
        cs_n = 1'b1; reg_sel = 1'b1; din = 16'h5555; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        bus_read(1'b1, 8'h00, q);
        check("R11 deselected write", q, 16'h1234);

        // R11: held strobe is one access, later data changes ignored
        @(negedge clk);
        cs_n = 1'b0; reg_sel = 1'b0; din = 16'h0010; wr_n = 1'b0;
        @(negedge clk);
        din = 16'h0011;
        @(negedge clk);
        din = 16'h0012;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
        bus_read(1'b0, 8'h00, q);
        check("R11 held strobe", q, 16'h0010);

        // R7: event arriving with the clearing read stays pending
        bus_write(1'b0, 16'h000E);
        bus_read(1'b1, 8'h02, q);
        check("R7 empty read", q, 16'h0000);
        bus_read(1'b1, 8'h00, q);
        check("R7 event kept", q, 16'h0002);

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 irq/rate after reset", {13'd0, irq, rate_mode}, 16'h0000);
        bus_read(1'b0, 8'h00, q);
        check("R1 index after reset", q, 16'h0000);
        bus_write(1'b0, 16'h000C);
        bus_read(1'b1, 8'h00, q);
        check("R1 enable after reset", q, 16'h0000);

        finish_run();
    end

endmodule